// File: doc/BRIEF.md
# Base-Delta Warp Operand Decompressor

This block turns a packed register operand back into a full warp operand of 32 lanes, each 32 bits wide, for a total of 1024 bits. A 2-bit tag comes with every packed frame and says how the frame was encoded. In the compressed encodings, the first 32-bit word of the frame is a base value. Lane 0 is the base itself. Every other lane is the base plus a small signed delta, and the delta is sign-extended before the add. A frame tagged as raw holds all 1024 bits already in lane order and goes through unchanged.

Frames arrive on a valid/ready input stream, and rebuilt operands leave on a valid/ready output stream. The output stage is one register deep, and the adder row in front of it works on all lanes in parallel, so an accepted frame appears at the output one clock later. The input is ready whenever the output register is empty or is being emptied in the same cycle. A consumer that holds ready low therefore stalls the producer after one frame. While stalled, the held operand must not change. A producer that raises valid must keep its tag and frame stable until they are accepted.

Top module: `bdc_decomp`

## Requirements
- R1: The tag `in_tag` selects the encoding: 0 means raw, 1 means zero-width delta, 2 means 8-bit deltas and 3 means 16-bit deltas.
- R2: A raw frame reaches `out_data` bit for bit unchanged.
- R3: For tags 1, 2 and 3, lane 0 (`out_data[31:0]`) equals the base, which is `in_data[31:0]`.
- R4: For tag 1, every one of the 32 lanes equals the base.
- R5: For tag 2, lane k (k = 1..31) equals the base plus the sign-extended byte `in_data[32+8*(k-1) +: 8]`.
- R6: For tag 3, lane k (k = 1..31) equals the base plus the sign-extended halfword `in_data[32+16*(k-1) +: 16]`.
- R7: The lane additions wrap modulo 2^32.
- R8: For tags 1, 2 and 3, input bits beyond the packed length have no effect on the output. The packed length is 32 bits for tag 1, 280 bits for tag 2 and 528 bits for tag 3.
- R9: A frame accepted at a rising edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high right after that edge.
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R11: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packed frame offered |
| in_ready | output | 1 | Frame is taken this cycle |
| in_tag | input | 2 | Encoding tag |
| in_data | input | 1024 | Packed frame |
| out_valid | output | 1 | Rebuilt operand present |
| out_ready | input | 1 | Consumer takes the operand |
| out_data | output | 1024 | Rebuilt operand, lane k in bits [32k+31:32k] |

## Verification
Two events can fall in the same cycle: the consumer draining the held operand, and a new frame being accepted into the same register. The bench sets `out_ready` at random on every cycle, which produces back-to-back transfers, stalls and refills on the draining edge. Every accepted frame is pushed into an ordered queue of expected operands. Each output transfer is compared against the head of that queue, so a frame that is lost, duplicated or overwritten during a stall shows up as a miscompare.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef enum logic [1:0] {
    TAG_RAW = 2'd0,
    TAG_D0  = 2'd1,
    TAG_D1  = 2'd2,
    TAG_D2  = 2'd3
  } bdc_tag_e;
endpackage

// File: rtl/bdc_lane.sv
module bdc_lane #(
  parameter int LANE_W  = 32,
  parameter int LANES   = 32,
  parameter int IDX     = 0,
  parameter int NARROW  = 8,
  parameter int WIDE    = 16,
  localparam int FRAME_W = LANE_W * LANES
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [1:0]         tag,
  output logic [LANE_W-1:0]  lane
);
  import bdc_pkg::*;

  logic [LANE_W-1:0] base;
  logic [LANE_W-1:0] raw_word;
  bdc_tag_e          kind;

  assign base     = frame[LANE_W-1:0];
  assign raw_word = frame[IDX*LANE_W +: LANE_W];
  assign kind     = bdc_tag_e'(tag);

  generate
    if (IDX == 0) begin : g_base_lane
      always_comb begin
        if (kind == TAG_RAW) lane = raw_word;
        else                 lane = base;
      end
    end else begin : g_delta_lane
      localparam int NOFF = LANE_W + (IDX - 1) * NARROW;
      localparam int WOFF = LANE_W + (IDX - 1) * WIDE;
      logic [NARROW-1:0] d_n;
      logic [WIDE-1:0]   d_w;
      logic [LANE_W-1:0] sx_n;
      logic [LANE_W-1:0] sx_w;
      assign d_n  = frame[NOFF +: NARROW];
      assign d_w  = frame[WOFF +: WIDE];
      assign sx_n = {{(LANE_W-NARROW){d_n[NARROW-1]}}, d_n};
      assign sx_w = {{(LANE_W-WIDE){d_w[WIDE-1]}}, d_w};
      always_comb begin
        unique case (kind)
          TAG_RAW: lane = raw_word;
          TAG_D0:  lane = base;
          TAG_D1:  lane = base + sx_n;
          default: lane = base + sx_w;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/bdc_expand.sv
module bdc_expand #(
  parameter int LANE_W  = 32,
  parameter int LANES   = 32,
  parameter int NARROW  = 8,
  parameter int WIDE    = 16,
  localparam int FRAME_W = LANE_W * LANES
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [1:0]         tag,
  output logic [FRAME_W-1:0] operand
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      bdc_lane #(
        .LANE_W(LANE_W), .LANES(LANES), .IDX(k),
        .NARROW(NARROW), .WIDE(WIDE)
      ) u_lane (
        .frame(frame),
        .tag  (tag),
        .lane (operand[k*LANE_W +: LANE_W])
      );
    end
  endgenerate
endmodule

// File: rtl/bdc_ostage.sv
module bdc_ostage #(
  parameter int W = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/bdc_decomp.sv
module bdc_decomp #(
  parameter int LANE_W  = 32,
  parameter int LANES   = 32,
  parameter int NARROW  = 8,
  parameter int WIDE    = 16,
  localparam int FRAME_W = LANE_W * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_tag,
  input  logic [FRAME_W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FRAME_W-1:0] out_data
);
  logic [FRAME_W-1:0] rebuilt;

  bdc_expand #(
    .LANE_W(LANE_W), .LANES(LANES), .NARROW(NARROW), .WIDE(WIDE)
  ) u_expand (
    .frame  (in_data),
    .tag    (in_tag),
    .operand(rebuilt)
  );

  bdc_ostage #(.W(FRAME_W)) u_ostage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (rebuilt),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (out_data)
  );
endmodule

// File: rtl/bdc_chk.sv
module bdc_chk #(
  parameter int LANE_W  = 32,
  parameter int LANES   = 32,
  localparam int FRAME_W = LANE_W * LANES
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         in_tag,
  input logic [FRAME_W-1:0] in_data,
  input logic               out_valid,
  input logic               out_ready,
  input logic [FRAME_W-1:0] out_data
);
  logic took;
  assign took = in_valid && in_ready;

  // R9
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid) |-> in_ready);

  // R2
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_tag == 2'd0) |=> out_data == $past(in_data));

  // R3
  base_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_tag != 2'd0) |=> out_data[LANE_W-1:0] == $past(in_data[LANE_W-1:0]));

  // R4
  zero_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (took && in_tag == 2'd1) |=> out_data == {LANES{$past(in_data[LANE_W-1:0])}});
endmodule

bind bdc_decomp bdc_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/bdc_decomp_bench.sv
module bdc_decomp_bench;
  localparam int FW = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_tag = 2'd0;
  logic [FW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [FW-1:0] out_data;

  int n_vec = 0;
  int n_bad = 0;
  logic [FW-1:0] expq[$];

  always #10 clk = ~clk;

  bdc_decomp u_bdc_decomp (.*);

  function automatic logic [FW-1:0] model(input logic [1:0] t, input logic [FW-1:0] d);
    logic [FW-1:0] r;
    logic [31:0] b;
    logic [7:0]  n8;
    logic [15:0] n16;
    b = d[31:0];
    r = '0;
    for (int k = 0; k < 32; k++) begin
      n8  = (k == 0) ? 8'd0 : d[32 + 8*(k-1) +: 8];
      n16 = (k == 0) ? 16'd0 : d[32 + 16*(k-1) +: 16];
      case (t)
        2'd0: r[32*k +: 32] = d[32*k +: 32];
        2'd1: r[32*k +: 32] = b;
        2'd2: r[32*k +: 32] = b + {{24{n8[7]}}, n8};
        default: r[32*k +: 32] = b + {{16{n16[15]}}, n16};
      endcase
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] rnd_frame();
    logic [FW-1:0] f;
    for (int i = 0; i < FW/32; i++) f[32*i +: 32] = $urandom;
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Per-cycle bookkeeping, evaluated after drives settle in the low phase.
  bit            acc_prev = 0;
  bit            stall_prev = 0;
  logic [FW-1:0] held;

  task automatic settle_and_score();
    #1;
    if (acc_prev) check(out_valid == 1'b1, "R9 out_valid after accept", FW'(out_valid), FW'(1));
    if (stall_prev) check(out_valid && out_data == held, "R10 hold under stall", out_data, held);
    check(in_ready == (!out_valid || out_ready), "R10 ready rule", FW'(in_ready), FW'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check(1'b0, "R9 spurious output", out_data, '0);
      else begin
        logic [FW-1:0] e;
        e = expq.pop_front();
        check(out_data == e, "R1-tagged operand R5 R6 R7 R8", out_data, e);
      end
    end
    stall_prev = out_valid && !out_ready;
    held = out_data;
    acc_prev = in_valid && in_ready;
    if (acc_prev) expq.push_back(model(in_tag, in_data));
  endtask

  task automatic direct(input logic [1:0] t, input logic [FW-1:0] d, input logic [FW-1:0] e, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_tag = t; in_data = d; out_ready = 1'b1;
    #1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid && out_data == e, req, out_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    // R11
    check(out_valid == 1'b0, "R11 reset out_valid", FW'(out_valid), FW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 idle after reset", FW'({out_valid, in_ready}), FW'(1));

    begin : directed
      logic [FW-1:0] d, e;
      // R2 raw
      d = rnd_frame();
      direct(2'd0, d, d, "R2 raw pass-through");
      // R4 and R8: garbage above base ignored
      d = rnd_frame(); d[31:0] = 32'hCAFE_0001;
      direct(2'd1, d, {32{32'hCAFE_0001}}, "R4 R8 zero-delta broadcast");
      // R5 negative byte deltas, R3 base lane
      d = rnd_frame(); d[31:0] = 32'd1000;
      for (int k = 1; k < 32; k++) d[32 + 8*(k-1) +: 8] = 8'h80;
      e = '0; e[31:0] = 32'd1000;
      for (int k = 1; k < 32; k++) e[32*k +: 32] = 32'd872;
      direct(2'd2, d, e, "R3 R5 byte delta -128");
      // R7 wrap with 16-bit deltas
      d = rnd_frame(); d[31:0] = 32'hFFFF_FFFF;
      for (int k = 1; k < 32; k++) d[32 + 16*(k-1) +: 16] = 16'd1;
      e = '0; e[31:0] = 32'hFFFF_FFFF;
      direct(2'd3, d, e, "R6 R7 wraparound");
      // R6 most negative halfword
      d = rnd_frame(); d[31:0] = 32'h0001_0000;
      for (int k = 1; k < 32; k++) d[32 + 16*(k-1) +: 16] = 16'h8000;
      e = '0; e[31:0] = 32'h0001_0000;
      for (int k = 1; k < 32; k++) e[32*k +: 32] = 32'h0000_8000;
      direct(2'd3, d, e, "R6 halfword delta -32768");
    end

    @(negedge clk);
    out_ready = 1'b1;
    #1;
    acc_prev = 0; stall_prev = 0; expq.delete();

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (!(in_valid && !acc_prev)) begin
        in_valid = ($urandom % 4) != 0;
        in_tag   = 2'($urandom);
        in_data  = rnd_frame();
      end
      out_ready = ($urandom % 3) != 0;
      settle_and_score();
    end

    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    settle_and_score();
    @(negedge clk);
    settle_and_score();
    check(expq.size() == 0, "R9 all frames delivered", FW'(expq.size()), FW'(0));
    finish_run();
  end
endmodule